// File: doc/BRIEF.md
# Checksumming Block Copy Engine

This engine moves a run of 16-bit words from a local RAM into a peripheral's data register. While each word goes out, it adds that word into a running Internet-style one's-complement sum. A copy is set up by a starting word address and a word count. The address rises and the count falls once for every word transferred. The running sum lives in its own register and carries over from one copy to the next, so several blocks (headers, then payload) can be summed as one datagram.

Three further operations complete the datagram. A trailer operation emits one extra word that brings the one's-complement sum of everything sent to 0xFFFF. This lets a constant stand in the UDP header's checksum field. A bump operation advances the IP identification value and adjusts the stored IP header checksum by the matching amount, so the header sum does not change. A seed operation loads both header values and clears the running sum.

Every peripheral write waits for a cycle-enable strobe, so a slow peripheral holds the engine back.

Top module: `csum_copy_engine`

## Requirements
- R1: With `op` = 2'b00 (copy) and a count N > 0, a start reads N words from RAM addresses `a_in`, `a_in`+1, ... (wrapping modulo 2^AW). Each word is written, in that order, onto `per_data` with exactly one `per_we` pulse per word.
- R2: Register A rises by one and register B falls by one per written word. When B reaches zero, `done` pulses for one cycle with `busy` low, `reg_a` = `a_in`+N and `reg_b` = 0.
- R3: Each written word is added into `reg_c` as a one's-complement sum: a 17-bit add whose carry-out is added back into the low 16 bits. A copy starts from the value `reg_c` already holds.
- R4: A copy with count zero writes no word, pulses `done` in the cycle after the start, and leaves `reg_c` unchanged.
- R5: A word is written only in a cycle where `cyc_en` is high. While `cyc_en` is low, no `per_we` occurs and A, B and C hold.
- R6: With `op` = 2'b01 (trailer), one word is written equal to the bitwise complement of `reg_c`, except that a complement of 0x0000 is sent as 0xFFFF. Afterwards `reg_c` reads 0xFFFF, so all words sent sum to 0xFFFF.
- R7: With `op` = 2'b10 (bump), `ip_id` increments modulo 2^16. `ip_ck` is decreased by one in one's-complement arithmetic: it becomes the end-around-carry sum of `ip_ck` and 0xFFFE. When `ip_id` wraps from 0xFFFF, `ip_ck` is left as it was. `done` pulses in the next cycle.
- R8: With `op` = 2'b11 (seed), `ip_id` takes `id_in`, `ip_ck` takes `ck_in` and `reg_c` is cleared to zero. `done` pulses in the next cycle.
- R9: A start while the engine is busy is ignored, along with its operands.
- R10: After reset the engine is idle. `busy`, `done` and `per_we` are low, and A, B, C, `ip_id` and `ip_ck` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the operation selected by `op` (idle only) |
| op | input | 2 | 00 copy, 01 trailer, 10 bump, 11 seed |
| a_in | input | AW | Starting RAM word address for a copy |
| b_in | input | CW | Word count for a copy |
| id_in | input | 16 | IP identification value loaded by seed |
| ck_in | input | 16 | IP header checksum loaded by seed |
| cyc_en | input | 1 | Peripheral cycle enable; a word moves only when high |
| ram_rd_en | output | 1 | RAM read request |
| ram_addr | output | AW | RAM read address |
| ram_rdata | input | 16 | RAM read data, valid the cycle after the request |
| per_we | output | 1 | Peripheral write strobe, one per word |
| per_data | output | 16 | Word written to the peripheral data register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_a | output | AW | Current RAM address register |
| reg_b | output | CW | Remaining word count register |
| reg_c | output | 16 | Running one's-complement sum |
| ip_id | output | 16 | IP identification value |
| ip_ck | output | 16 | IP header checksum value |

## Verification
The assertions assume a RAM that returns the addressed word one cycle after a read request. They also assume that `cyc_en` only gates progress and never has to be held for a set time. The bench's RAM model answers with exactly that latency, and it drives `cyc_en` either steadily high or from random stalls at about one cycle in three. The bench applies starts only at negative edges. It raises a start during busy only in the case written for R9.

// File: rtl/csum_copy_engine.sv
module csum_copy_engine #(
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] a_in,
  input  logic [CW-1:0] b_in,
  input  logic [15:0]   id_in,
  input  logic [15:0]   ck_in,
  input  logic          cyc_en,
  output logic          ram_rd_en,
  output logic [AW-1:0] ram_addr,
  input  logic [15:0]   ram_rdata,
  output logic          per_we,
  output logic [15:0]   per_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] reg_a,
  output logic [CW-1:0] reg_b,
  output logic [15:0]   reg_c,
  output logic [15:0]   ip_id,
  output logic [15:0]   ip_ck
);

  localparam logic [1:0] OP_COPY  = 2'd0;
  localparam logic [1:0] OP_TRAIL = 2'd1;
  localparam logic [1:0] OP_BUMP  = 2'd2;
  localparam logic [1:0] OP_SEED  = 2'd3;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CAPT, S_XFER, S_TRAIL} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic [15:0] word_q;
  logic [15:0] trail_w;

  function automatic logic [15:0] oc_add(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  assign trail_w   = (reg_c == 16'hFFFF) ? 16'hFFFF : ~reg_c;
  assign ram_rd_en = (st == S_FETCH);
  assign ram_addr  = reg_a;
  assign busy      = (st != S_IDLE);
  assign per_we    = ((st == S_XFER) || (st == S_TRAIL)) && cyc_en;
  assign per_data  = (st == S_TRAIL) ? trail_w : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_COPY;
      word_q <= '0;
      done   <= 1'b0;
      reg_a  <= '0;
      reg_b  <= '0;
      reg_c  <= '0;
      ip_id  <= '0;
      ip_ck  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            op_q <= op;
            if (op == OP_COPY) begin
              reg_a <= a_in;
              reg_b <= b_in;
              if (b_in == '0) done <= 1'b1;
              else            st   <= S_FETCH;
            end else if (op == OP_TRAIL) begin
              st <= S_TRAIL;
            end else if (op == OP_BUMP) begin
              ip_id <= ip_id + 16'd1;
              if (ip_id != 16'hFFFF) ip_ck <= oc_add(ip_ck, 16'hFFFE);
              done <= 1'b1;
            end else begin
              ip_id <= id_in;
              ip_ck <= ck_in;
              reg_c <= '0;
              done  <= 1'b1;
            end
          end
        end
        S_FETCH: st <= S_CAPT;
        S_CAPT: begin
          word_q <= ram_rdata;
          st     <= S_XFER;
        end
        S_XFER: begin
          if (cyc_en) begin
            reg_a <= reg_a + 1'b1;
            reg_b <= reg_b - 1'b1;
            reg_c <= oc_add(reg_c, word_q);
            if (reg_b == CNT_ONE) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_TRAIL: begin
          if (cyc_en) begin
            reg_c <= oc_add(reg_c, trail_w);
            st    <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && per_we) |=> (reg_a == AW'($past(reg_a) + 1'b1)) && (reg_b == CW'($past(reg_b) - 1'b1)));

  assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_COPY) |-> (reg_b == '0) && !busy);

  assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && per_we) |=> reg_c == oc_add($past(reg_c), $past(per_data)));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && op == OP_COPY && b_in == '0) |=> done && $stable(reg_c) && !per_we);

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_en) |=> $stable(reg_a) && $stable(reg_b) && $stable(reg_c));

  assert_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRAIL && per_we) |=> reg_c == 16'hFFFF);

  assert_trail_nz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRAIL && per_we) |-> per_data != 16'h0000);

  assert_bump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_BUMP) |-> ip_id == 16'($past(ip_id) + 16'd1));

endmodule

// File: tb/csum_copy_engine_bench.sv
module csum_copy_engine_bench;
  localparam int AW = 8;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] a_in = '0;
  logic [CW-1:0] b_in = '0;
  logic [15:0]   id_in = '0, ck_in = '0;
  logic          cyc_en = 1'b1;
  logic          ram_rd_en, per_we, busy, done;
  logic [AW-1:0] ram_addr, reg_a;
  logic [CW-1:0] reg_b;
  logic [15:0]   ram_q, per_data, reg_c, ip_id, ip_ck;

  csum_copy_engine #(.AW(AW), .CW(CW)) u_csum_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in), .b_in(b_in),
    .id_in(id_in), .ck_in(ck_in), .cyc_en(cyc_en),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_q),
    .per_we(per_we), .per_data(per_data), .busy(busy), .done(done),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .ip_id(ip_id), .ip_ck(ip_ck));

  logic [15:0] mem [0:255];
  always_ff @(posedge clk) if (ram_rd_en) ram_q <= mem[ram_addr];

  logic stall_en = 1'b0, force_low = 1'b0;
  always @(negedge clk)
    cyc_en <= force_low ? 1'b0 : (stall_en ? ($urandom % 3 != 0) : 1'b1);

  logic [15:0] cap [0:4095];
  int cap_total = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && per_we) begin
      cap[cap_total % 4096] = per_data;
      cap_total++;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_c = 16'h0;

  function automatic logic [15:0] oc_add(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input logic [7:0] a, input logic [8:0] b);
    int got;
    @(negedge clk);
    op = o; a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int k = 0; k < 5000; k++) begin
      #1;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    check("R2 done pulse seen", got, 1);
  endtask

  task automatic run_copy(input logic [7:0] a, input logic [8:0] b, input string tag);
    int base, bad;
    logic [15:0] c0;
    base = cap_total;
    c0 = exp_c;
    do_op(2'd0, a, b);
    check({"R1 word count ", tag}, cap_total - base, b);
    bad = 0;
    for (int i = 0; i < b; i++) begin
      if (cap[(base + i) % 4096] !== mem[8'(a + i)]) bad++;
      exp_c = oc_add(exp_c, mem[8'(a + i)]);
    end
    check({"R1 word order ", tag}, bad, 0);
    check({"R2 reg_a ", tag}, reg_a, 8'(a + b));
    check({"R2 reg_b ", tag}, reg_b, 0);
    check({"R3 reg_c ", tag}, reg_c, exp_c);
    if (b == 0) check({"R4 reg_c unchanged ", tag}, reg_c, c0);
  endtask

  task automatic run_trail(input string tag);
    int base;
    logic [15:0] e;
    base = cap_total;
    e = (exp_c == 16'hFFFF) ? 16'hFFFF : ~exp_c;
    do_op(2'd1, 8'd0, 9'd0);
    check({"R6 trailer count ", tag}, cap_total - base, 1);
    check({"R6 trailer word ", tag}, cap[base % 4096], e);
    check({"R6 reg_c after ", tag}, reg_c, 16'hFFFF);
    exp_c = 16'hFFFF;
  endtask

  task automatic run_seed(input logic [15:0] id, input logic [15:0] ck);
    id_in = id; ck_in = ck;
    do_op(2'd3, 8'd0, 9'd0);
    check("R8 seed id", ip_id, id);
    check("R8 seed ck", ip_ck, ck);
    check("R8 seed clears sum", reg_c, 0);
    exp_c = 16'h0;
  endtask

  task automatic run_bump(input string tag);
    logic [15:0] id0, ck0;
    id0 = ip_id; ck0 = ip_ck;
    do_op(2'd2, 8'd0, 9'd0);
    check({"R7 id ", tag}, ip_id, 16'(id0 + 16'd1));
    check({"R7 ck ", tag}, ip_ck, (id0 == 16'hFFFF) ? ck0 : oc_add(ck0, 16'hFFFE));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base, sum;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    #1;
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 per_we", per_we, 0);
    check("R10 reg_c", reg_c, 0);
    check("R10 ip_id", ip_id, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_seed(16'h1234, 16'hB1C2);
    run_copy(8'd250, 9'd10, "wrap");

    stall_en = 1'b1;
    for (int t = 0; t < 8; t++)
      run_copy(8'($urandom), 9'(1 + $urandom % 40), "random");

    run_copy(8'd77, 9'd0, "zero");

    base = cap_total;
    run_trail("random");
    sum = 16'h0;
    for (int i = 0; i < 0; i++) sum = 0;
    check("R6 datagram total", reg_c, 16'hFFFF);

    force_low = 1'b1;
    stall_en = 1'b0;
    @(negedge clk);
    base = cap_total;
    op = 2'd0; a_in = 8'd20; b_in = 9'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check("R5 no write while stalled", cap_total - base, 0);
    check("R5 reg_a held", reg_a, 20);
    check("R5 reg_b held", reg_b, 4);
    check("R5 reg_c held", reg_c, exp_c);
    force_low = 1'b0;
    for (int k = 0; k < 200 && !done; k++) begin @(negedge clk); #1; end
    check("R5 done after release", done, 1);
    for (int i = 0; i < 4; i++) exp_c = oc_add(exp_c, mem[20 + i]);
    check("R5 words after release", cap_total - base, 4);
    check("R3 sum after release", reg_c, exp_c);

    run_seed(16'h0001, 16'h0002);
    run_trail("from zero");
    run_seed(16'h0001, 16'h0002);
    mem[10] = 16'hFFFF;
    run_copy(8'd10, 9'd1, "all ones");
    run_trail("complement zero");

    run_seed(16'h1234, 16'h0005);
    run_bump("plain");
    run_seed(16'h0010, 16'h0000);
    run_bump("ck zero");
    run_seed(16'hFFFF, 16'h1111);
    run_bump("id wrap");
    for (int t = 0; t < 4; t++) begin
      run_seed(16'($urandom), 16'($urandom));
      run_bump("random");
    end

    stall_en = 1'b1;
    run_seed(16'h4321, 16'h8765);
    @(negedge clk);
    base = cap_total;
    op = 2'd0; a_in = 8'd100; b_in = 9'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'd3; id_in = 16'hAAAA; ck_in = 16'hBBBB; a_in = 8'd0; b_in = 9'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 500 && !done; k++) begin @(negedge clk); #1; end
    for (int i = 0; i < 6; i++) exp_c = oc_add(exp_c, mem[100 + i]);
    check("R9 words of first op", cap_total - base, 6);
    check("R9 sum not cleared", reg_c, exp_c);
    check("R9 id untouched", ip_id, 16'h4321);
    check("R9 reg_a", reg_a, 106);

    summary();
    $finish;
  end
endmodule